// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block is the device end of a PS/2 link. It takes one byte at a time from local logic and sends it to the host as a framed serial word. The device generates the clock on the link itself. Both link lines are open-drain. The block has two enable outputs, and each one pulls its line low when asserted. It reads back the real level of each line through a two-flop synchronizer.

Before it drives anything, the block waits for the host to stop holding the clock low. It then lets a guard interval pass and samples the clock a second time. If the host has pulled the clock low again, the block goes back to waiting. If the clock is high but the host is holding data low (a request to send), the block gives up on the byte without driving either line and pulses an abort flag. Otherwise it sends the eleven-bit frame with fixed setup, clock-low and hold intervals. The stop bit carries an extended clock-low period. All intervals are whole numbers of microseconds, converted to system clocks by one parameter.

The byte input uses a valid/ready handshake. The block raises `tx_ready` only while idle. A byte is taken on a rising clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the frame completes or aborts, so local logic that holds `tx_valid` high is simply back-pressured. Its byte is not sampled until the next idle cycle.

Top module: `ps2dev_tx`

## Requirements
- R1: `tx_ready` is high exactly when the block is idle. A byte is accepted on an edge with `tx_valid` and `tx_ready` both high. `tx_ready` then stays low, and `tx_data` is ignored, until the completion or abort pulse.
- R2: After accepting a byte, the block drives neither line while the synchronized clock line is low. It starts a frame no sooner than GUARD_US microseconds after it first sees the clock high.
- R3: If the clock line is low when the guard interval ends, the block returns to waiting for a high clock and runs a fresh full guard interval before sending.
- R4: If the clock is high but the data line is low when the guard interval ends, the block drives no bit, pulses `tx_abort` for one cycle and becomes ready again. `tx_done` and `tx_abort` are never high together.
- R5: Bits are presented in this order: a 0 start bit, then the eight data bits with bit 0 first, then the parity bit, then a 1 stop bit. The data line holds steady while the clock line is pulled low.
- R6: The parity bit makes the count of ones over the eight data bits plus parity odd.
- R7: For each of the first ten bits, data is placed SETUP_US before the clock is pulled low. The clock is then held low for exactly LOW_US, and released for HOLD_US before the next bit is placed.
- R8: For the stop bit, data is released high for SETUP_US, then the clock is held low for STOP_LOW_US.
- R9: A finished frame gives one single-cycle `tx_done` pulse, and both lines are released from that cycle on. Whenever `tx_ready` is high, neither line enable is asserted.
- R10: An active reset releases both lines at once, clears any partial frame and leaves the block idle and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block idle and accepting a byte |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: host requested to send, byte dropped |
| ps2_clk_in | input | 1 | Sensed level of the clock line |
| ps2_dat_in | input | 1 | Sensed level of the data line |
| ps2_clk_oe | output | 1 | Pull clock line low when 1 |
| ps2_dat_oe | output | 1 | Pull data line low when 1 |

## Verification
The bench builds the block with CLKS_PER_US set to 2 and keeps every microsecond value at its default. This makes a whole frame about 2,500 cycles, and the 370 us stop phase becomes 740 cycles. Every interval can therefore be measured exactly across many scenarios: clock-low widths, setup-plus-hold gaps and guard delays. Inhibit, recheck and abort cases are built with a host model that wires the lines open-drain. Byte values 0x00, 0xFF, 0xA5 and 0x37 cover both parity outcomes.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 2;  // start + data + parity

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HIGH,
    ST_GUARD,
    ST_SETUP,
    ST_LOW,
    ST_HOLD,
    ST_STOP_SETUP,
    ST_STOP_LOW
  } tx_state_t;

  function automatic logic odd_fill(input logic [DATA_W-1:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '1;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ps2tx_timer.sv
module ps2tx_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] dur,
  output logic          expire
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign expire = (cnt == dur - 1'b1);

endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame
  import ps2tx_pkg::*;
(
  input  logic [DATA_W-1:0]     byte_in,
  output logic [FRAME_BITS-1:0] bits
);

  always_comb begin
    bits[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) bits[i+1] = byte_in[i];
    bits[FRAME_BITS-1] = odd_fill(byte_in);
  end

endmodule

// File: rtl/ps2dev_tx.sv
module ps2dev_tx
  import ps2tx_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int SETUP_US    = 20,
  parameter int LOW_US      = 40,
  parameter int HOLD_US     = 20,
  parameter int GUARD_US    = 50,
  parameter int STOP_LOW_US = 370,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       tx_abort,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe
);

  localparam int SETUP_CLKS = SETUP_US * CLKS_PER_US;
  localparam int LOW_CLKS   = LOW_US * CLKS_PER_US;
  localparam int HOLD_CLKS  = HOLD_US * CLKS_PER_US;
  localparam int GUARD_CLKS = GUARD_US * CLKS_PER_US;
  localparam int STOP_CLKS  = STOP_LOW_US * CLKS_PER_US;
  localparam int MAX_A      = (SETUP_CLKS > LOW_CLKS) ? SETUP_CLKS : LOW_CLKS;
  localparam int MAX_B      = (HOLD_CLKS > GUARD_CLKS) ? HOLD_CLKS : GUARD_CLKS;
  localparam int MAX_C      = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CLKS   = (MAX_C > STOP_CLKS) ? MAX_C : STOP_CLKS;
  localparam int TW         = $clog2(MAX_CLKS + 1);
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  tx_state_t              state, state_n;
  logic [IDX_W-1:0]       bit_idx;
  logic [DATA_W-1:0]      byte_q;
  logic [FRAME_BITS-1:0]  frame_bits;
  logic                   clk_s, dat_s;
  logic                   expire, restart;
  logic [TW-1:0]          dur;
  logic                   finish, abort_go;

  ps2tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ps2_clk_in, ps2_dat_in}),
    .q     ({clk_s, dat_s})
  );

  ps2tx_frame u_frame (
    .byte_in (byte_q),
    .bits    (frame_bits)
  );

  ps2tx_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .dur     (dur),
    .expire  (expire)
  );

  always_comb begin
    unique case (state)
      ST_GUARD:      dur = TW'(GUARD_CLKS);
      ST_SETUP:      dur = TW'(SETUP_CLKS);
      ST_LOW:        dur = TW'(LOW_CLKS);
      ST_HOLD:       dur = TW'(HOLD_CLKS);
      ST_STOP_SETUP: dur = TW'(SETUP_CLKS);
      ST_STOP_LOW:   dur = TW'(STOP_CLKS);
      default:       dur = TW'(MAX_CLKS);
    endcase
  end

  always_comb begin
    state_n  = state;
    finish   = 1'b0;
    abort_go = 1'b0;
    unique case (state)
      ST_IDLE:
        if (tx_valid) state_n = ST_WAIT_HIGH;
      ST_WAIT_HIGH:
        if (clk_s) state_n = ST_GUARD;
      ST_GUARD:
        if (expire) begin
          if (!clk_s) begin
            state_n = ST_WAIT_HIGH;
          end else if (!dat_s) begin
            state_n  = ST_IDLE;
            abort_go = 1'b1;
          end else begin
            state_n = ST_SETUP;
          end
        end
      ST_SETUP:
        if (expire) state_n = ST_LOW;
      ST_LOW:
        if (expire) state_n = ST_HOLD;
      ST_HOLD:
        if (expire) state_n = (bit_idx == LAST_IDX) ? ST_STOP_SETUP : ST_SETUP;
      ST_STOP_SETUP:
        if (expire) state_n = ST_STOP_LOW;
      ST_STOP_LOW:
        if (expire) begin
          state_n = ST_IDLE;
          finish  = 1'b1;
        end
      default:
        state_n = ST_IDLE;
    endcase
  end

  assign restart = (state_n != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_idx  <= '0;
      byte_q   <= '0;
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      state    <= state_n;
      tx_done  <= finish;
      tx_abort <= abort_go;
      if (state == ST_IDLE && tx_valid) begin
        byte_q  <= tx_data;
        bit_idx <= '0;
      end else if (state == ST_HOLD && expire && bit_idx != LAST_IDX) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign tx_ready   = (state == ST_IDLE);
  assign ps2_clk_oe = (state == ST_LOW) || (state == ST_STOP_LOW);
  assign ps2_dat_oe = ((state == ST_SETUP) || (state == ST_LOW) || (state == ST_HOLD))
                      && !frame_bits[bit_idx];

endmodule

// File: rtl/ps2tx_checker.sv
module ps2tx_checker #(
  parameter int LOW_CLKS  = 80,
  parameter int STOP_CLKS = 740
) (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_done,
  input logic tx_abort,
  input logic ps2_clk_oe,
  input logic ps2_dat_oe
);

  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= 0;
    else if (ps2_clk_oe) low_run <= low_run + 1;
    else                 low_run <= 0;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);  // R1

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!ps2_clk_oe && !ps2_dat_oe && !tx_done));  // R4

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_clk_oe && $past(ps2_clk_oe)) |-> $stable(ps2_dat_oe));  // R5

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> (low_run == LOW_CLKS || low_run == STOP_CLKS));  // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);  // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!ps2_clk_oe && !ps2_dat_oe));  // R9

endmodule

bind ps2dev_tx ps2tx_checker #(
  .LOW_CLKS  (LOW_US * CLKS_PER_US),
  .STOP_CLKS (STOP_LOW_US * CLKS_PER_US)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_done    (tx_done),
  .tx_abort   (tx_abort),
  .ps2_clk_oe (ps2_clk_oe),
  .ps2_dat_oe (ps2_dat_oe)
);

// File: tb/sim_ps2dev_tx.sv
module sim_ps2dev_tx;

  localparam int K     = 2;
  localparam int GUARD = 50 * K;
  localparam int SETUP = 20 * K;
  localparam int LOW   = 40 * K;
  localparam int GAP   = 40 * K;
  localparam int STOPL = 370 * K;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_done, tx_abort;
  logic       ps2_clk_oe, ps2_dat_oe;
  logic       host_clk_low = 1'b0;
  logic       host_dat_low = 1'b0;
  logic       ps2_clk_in, ps2_dat_in;

  int errs = 0;
  int checks = 0;

  assign ps2_clk_in = ~(ps2_clk_oe | host_clk_low);
  assign ps2_dat_in = ~(ps2_dat_oe | host_dat_low);

  always #10 clk = ~clk;

  ps2dev_tx #(.CLKS_PER_US(K)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_abort(tx_abort),
    .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // observe the link until a completion/abort pulse (plus a few cycles) or timeout
  task automatic capture(input bit inject,
                         output logic [10:0] bits, output int nb, output int t_first,
                         output int lows[11], output int gaps[11],
                         output int done_w, output int abort_w, output bit ready_bad);
    int t = 0;
    int tail = -1;
    int rise_t = 0;
    int fall_t = 0;
    bit prev_c = 1'b0;
    bit prev_d = 1'b0;
    bits = '1; nb = 0; t_first = -1; done_w = 0; abort_w = 0; ready_bad = 1'b0;
    for (int i = 0; i < 11; i++) begin lows[i] = -1; gaps[i] = -1; end
    while (t < 8000 && tail != 0) begin
      @(negedge clk);
      if (inject && t == 100) begin tx_data = 8'h3C; tx_valid = 1'b1; end
      if (inject && t == 1000) tx_valid = 1'b0;
      if (ps2_dat_oe && !prev_d && t_first < 0) t_first = t;
      if (ps2_clk_oe && !prev_c) begin
        if (nb < 11) bits[nb] = ps2_dat_in;
        if (nb > 0 && nb < 12) gaps[nb-1] = t - fall_t;
        rise_t = t;
      end
      if (!ps2_clk_oe && prev_c) begin
        if (nb < 11) lows[nb] = t - rise_t;
        nb++;
        fall_t = t;
      end
      if (tx_done) done_w++;
      if (tx_abort) abort_w++;
      if (tx_ready && done_w == 0 && abort_w == 0) ready_bad = 1'b1;
      if ((tx_done || tx_abort) && tail < 0) tail = 3;
      else if (tail > 0) tail--;
      prev_c = ps2_clk_oe;
      prev_d = ps2_dat_oe;
      t++;
    end
  endtask

  task automatic check_frame(input logic [7:0] b, input logic [10:0] bits, input int nb,
                             input int lows[11], input int gaps[11], input int done_w,
                             input int abort_w, input bit ready_bad);
    chk(nb == 11, "R5", "clock pulse count", nb, 11);
    chk(bits[0] == 1'b0, "R5", "start bit", bits[0], 0);
    chk(bits[8:1] == b, "R5", "data bits lsb first", bits[8:1], b);
    chk(bits[9] == ~(^b), "R6", "odd parity bit", bits[9], ~(^b));
    chk(bits[10] == 1'b1, "R8", "stop bit level", bits[10], 1);
    for (int i = 0; i < 10; i++) begin
      chk(lows[i] == LOW, "R7", $sformatf("clock low width bit %0d", i), lows[i], LOW);
      chk(gaps[i] == GAP, "R7", $sformatf("hold+setup gap after bit %0d", i), gaps[i], GAP);
    end
    chk(lows[10] == STOPL, "R8", "stop clock low width", lows[10], STOPL);
    chk(done_w == 1, "R9", "done pulse width", done_w, 1);
    chk(abort_w == 0, "R4", "no abort on good frame", abort_w, 0);
    chk(!ready_bad, "R1", "ready low while busy", ready_bad, 0);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R9", "lines released after frame",
        {ps2_clk_oe, ps2_dat_oe}, 0);
    chk(tx_ready, "R1", "ready after done", tx_ready, 1);
  endtask

  task automatic t_reset_state;
    chk(tx_ready, "R10", "ready after reset", tx_ready, 1);
    chk(!ps2_clk_oe && !ps2_dat_oe, "R10", "lines released in reset",
        {ps2_clk_oe, ps2_dat_oe}, 0);
    chk(!tx_done && !tx_abort, "R10", "status quiet after reset", {tx_done, tx_abort}, 0);
  endtask

  task automatic t_plain_frame(input logic [7:0] b, input bit inject);
    logic [10:0] bits; int nb, tf, dw, aw; int lows[11]; int gaps[11]; bit rb;
    send_byte(b);
    chk(!tx_ready, "R1", "ready drops after accept", tx_ready, 0);
    capture(inject, bits, nb, tf, lows, gaps, dw, aw, rb);
    chk(tf >= GUARD - 3 && tf <= GUARD + 4, "R2", "guard delay before first drive", tf, GUARD);
    check_frame(b, bits, nb, lows, gaps, dw, aw, rb);
    if (inject) begin
      tx_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(tx_ready && !ps2_dat_oe, "R1", "held-off byte not taken", tx_ready, 1);
    end
  endtask

  task automatic t_inhibit;
    logic [10:0] bits; int nb, tf, dw, aw; int lows[11]; int gaps[11]; bit rb;
    bit drove = 1'b0;
    host_clk_low = 1'b1;
    send_byte(8'h81);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ps2_clk_oe || ps2_dat_oe) drove = 1'b1;
    end
    chk(!drove, "R2", "no drive while clock inhibited", drove, 0);
    chk(!tx_ready, "R1", "busy while inhibited", tx_ready, 0);
    host_clk_low = 1'b0;
    capture(1'b0, bits, nb, tf, lows, gaps, dw, aw, rb);
    chk(tf >= GUARD && tf <= GUARD + 6, "R2", "guard after inhibit release", tf, GUARD);
    check_frame(8'h81, bits, nb, lows, gaps, dw, aw, rb);
  endtask

  task automatic t_recheck;
    logic [10:0] bits; int nb, tf, dw, aw; int lows[11]; int gaps[11]; bit rb;
    bit drove = 1'b0;
    host_clk_low = 1'b1;
    send_byte(8'h37);
    repeat (20) @(negedge clk);
    host_clk_low = 1'b0;
    repeat (10 * K) begin
      @(negedge clk);
      if (ps2_clk_oe || ps2_dat_oe) drove = 1'b1;
    end
    host_clk_low = 1'b1;
    repeat (100 * K) begin
      @(negedge clk);
      if (ps2_clk_oe || ps2_dat_oe) drove = 1'b1;
    end
    chk(!drove, "R3", "no drive when clock low at guard end", drove, 0);
    host_clk_low = 1'b0;
    capture(1'b0, bits, nb, tf, lows, gaps, dw, aw, rb);
    chk(tf >= GUARD && tf <= GUARD + 6, "R3", "fresh guard after recheck", tf, GUARD);
    check_frame(8'h37, bits, nb, lows, gaps, dw, aw, rb);
  endtask

  task automatic t_abort;
    logic [10:0] bits; int nb, tf, dw, aw; int lows[11]; int gaps[11]; bit rb;
    host_dat_low = 1'b1;
    send_byte(8'h55);
    capture(1'b0, bits, nb, tf, lows, gaps, dw, aw, rb);
    chk(aw == 1, "R4", "abort pulse width", aw, 1);
    chk(dw == 0, "R4", "no done on abort", dw, 0);
    chk(nb == 0 && tf < 0, "R4", "nothing driven on abort", nb, 0);
    chk(tx_ready, "R4", "ready after abort", tx_ready, 1);
    host_dat_low = 1'b0;
  endtask

  task automatic t_reset_midframe;
    send_byte(8'hC3);
    while (!ps2_clk_oe) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!ps2_clk_oe && !ps2_dat_oe, "R10", "reset releases lines mid-frame",
        {ps2_clk_oe, ps2_dat_oe}, 0);
    chk(tx_ready, "R10", "idle during reset", tx_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ps2_clk_oe && !ps2_dat_oe && !tx_done, "R10", "no partial frame after reset",
        {ps2_clk_oe, ps2_dat_oe, tx_done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_plain_frame(8'hA5, 1'b0);
    t_plain_frame(8'h00, 1'b0);
    t_plain_frame(8'hFF, 1'b1);
    t_inhibit();
    t_recheck();
    t_abort();
    t_reset_midframe();
    t_plain_frame(8'h5A, 1'b0);
    summary();
    $finish;
  end

endmodule